// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned N-bit words using a single one-bit full adder and a one-bit carry register. The full adder is reused for every column, one column per clock. A start pulse copies both operands into two right-shifting registers and clears the carry. On each of the next N clocks, the low bits of the two registers and the stored carry produce one sum bit and one new carry.

The sum bit enters the top of the first operand register as that register moves down by one place. The second operand register moves down in step and takes in zeros. When N columns are done, the first register holds the N-bit sum, the carry register holds the carry out of the top column, and a one-cycle done pulse is issued. Both results stay on the outputs until the next accepted start. A new start may be given in the same cycle as the done pulse.

Top module: `sadd_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `sum` and `carry_out` are all 0.
- R2: A start seen at a clock edge while `busy` is 0 loads both operands. `busy` is 1 from the next cycle on.
- R3: At the end of an addition, `sum` equals bits N-1..0 of op_a + op_b. The columns are formed least significant first, and each sum bit is the XOR of the two operand bits and the incoming carry.
- R4: At the end of an addition, `carry_out` equals bit N of op_a + op_b. Each column's carry is 1 when at least two of its three inputs are 1, and it feeds the next higher column.
- R5: `busy` stays 1 for exactly N cycles. `done` is then 1 for exactly one cycle, which is the first cycle with `busy` at 0. `done` and `busy` are never 1 together.
- R6: A start given while `busy` is 1 has no effect. The running addition finishes with its own result and on its own schedule.
- R7: Between `done` and the next accepted start, `sum` and `carry_out` hold their values.
- R8: A start given in the cycle `done` is 1 is accepted, so additions can run back to back with no idle gap.
- R9: Every accepted start clears the carry to 0 before the lowest column. A carry of 1 left over from the previous addition does not change the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an addition |
| op_a | input | N | First operand, sampled when a start is accepted |
| op_b | input | N | Second operand, sampled when a start is accepted |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum | output | N | Low N bits of the result |
| carry_out | output | 1 | Carry out of the top column |

## Verification
Two events can fall in the same cycle: the done pulse of one addition and the accepted start of the next. The driver gives every new start in the first cycle where `busy` reads 0. Chained operations therefore always launch during the done cycle. The bench then checks that `busy` rises, that the carry reads 0, and that the next result and its cycle count are correct. A second collision is a start given in the middle of a running addition. The bench judges it at the ports: the running addition must report its own result after exactly N busy cycles.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_SHIFT = 2'd1,
        SR_LOAD  = 2'd2
    } sr_op_e;

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg
    import sadd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sr_op_e       op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q,
    output logic         lsb
);

    typedef struct packed {
        logic [W-1:0] word;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            SR_SHIFT: st_d.word = {ser_in, st_q.word[W-1:1]};
            SR_LOAD:  st_d.word = par_in;
            default:  st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q   = st_q.word;
    assign lsb = st_q.word[0];

    AST_HOLD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SR_HOLD) |=> $stable(q)); // R7

endmodule

// File: rtl/sadd_fa.sv
module sadd_fa (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry
);

    typedef struct packed {
        logic cy;
    } fa_state_t;

    fa_state_t st_d, st_q;
    logic      maj;

    always_comb begin
        sum_bit = a_bit ^ b_bit ^ st_q.cy;
        maj     = (a_bit & b_bit) | (a_bit & st_q.cy) | (b_bit & st_q.cy);
        st_d    = st_q;
        if (clear)     st_d.cy = 1'b0;
        else if (step) st_d.cy = maj;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry = st_q.cy;

    AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !carry); // R9
    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(carry)); // R7

endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);

    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] left;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        load      = start && !st_q.busy;
        step      = st_q.busy;
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.left = CW'(N);
        end else if (st_q.busy) begin
            st_d.left = st_q.left - CW'(1);
            if (st_q.left == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_RUN_STARTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (st_q.left == CW'(N))); // R2
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R6

endmodule

// File: rtl/sadd_top.sv
module sadd_top
    import sadd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] sum,
    output logic         carry_out
);

    logic   load, step;
    logic   a_lsb, b_lsb, s_bit, cy;
    sr_op_e sr_op;
    logic [N-1:0] b_word;

    sadd_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    always_comb begin
        if (load)      sr_op = SR_LOAD;
        else if (step) sr_op = SR_SHIFT;
        else           sr_op = SR_HOLD;
    end

    sadd_shreg #(.W(N)) u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (sr_op),
        .par_in (op_a),
        .ser_in (s_bit),
        .q      (sum),
        .lsb    (a_lsb)
    );

    sadd_shreg #(.W(N)) u_breg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (sr_op),
        .par_in (op_b),
        .ser_in (1'b0),
        .q      (b_word),
        .lsb    (b_lsb)
    );

    sadd_fa u_fa (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .step    (step),
        .a_bit   (a_lsb),
        .b_bit   (b_lsb),
        .sum_bit (s_bit),
        .carry   (cy)
    );

    assign carry_out = cy;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_B_EMPTY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (b_word == '0)); // R3

endmodule

// File: tb/test_sadd_top.sv
module test_sadd_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic        st16 = 1'b0, st4 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0, sum16;
    logic [3:0]  a4 = '0, b4 = '0, sum4;
    logic        busy16, done16, co16, busy4, done4, co4;

    int checks = 0;
    int fails  = 0;

    sadd_top #(.N(16)) i_sadd_top (
        .clk(clk), .rst_n(rst_n), .start(st16), .op_a(a16), .op_b(b16),
        .busy(busy16), .done(done16), .sum(sum16), .carry_out(co16));

    sadd_top #(.N(4)) i_sadd_top_n4 (
        .clk(clk), .rst_n(rst_n), .start(st4), .op_a(a4), .op_b(b4),
        .busy(busy4), .done(done4), .sum(sum4), .carry_out(co4));

    logic [16:0] q16[$];
    logic [4:0]  q4[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitors
    int bc16 = 0, bc4 = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy16) bc16++;
            if (done16) begin
                check(bc16 == 16, "R5 busy cycles n16", bc16, 16);
                bc16 = 0;
                if (q16.size() == 0) check(0, "R3 unexpected done n16", 1, 0);
                else begin
                    logic [16:0] e;
                    e = q16.pop_front();
                    check(sum16 == e[15:0], "R3 sum n16", sum16, e[15:0]);
                    check(co16 == e[16], "R4 carry n16", co16, e[16]);
                end
            end
            if (busy4) bc4++;
            if (done4) begin
                check(bc4 == 4, "R5 busy cycles n4", bc4, 4);
                bc4 = 0;
                if (q4.size() == 0) check(0, "R3 unexpected done n4", 1, 0);
                else begin
                    logic [4:0] e;
                    e = q4.pop_front();
                    check(sum4 == e[3:0], "R3 sum n4", sum4, e[3:0]);
                    check(co4 == e[4], "R4 carry n4", co4, e[4]);
                end
            end
        end
    end

    logic pd16 = 1'b0, pd4 = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pd16 && done16) check(0, "R5 done width n16", 2, 1);
            if (pd4 && done4)   check(0, "R5 done width n4", 2, 1);
            if (busy16 && done16) check(0, "R5 busy with done n16", 1, 0);
        end
        pd16 = done16;
        pd4  = done4;
    end

    task automatic go16(input logic [15:0] a, input logic [15:0] b);
        bit in_done;
        @(negedge clk);
        while (busy16) @(negedge clk);
        in_done = done16;
        st16 = 1'b1; a16 = a; b16 = b;
        q16.push_back({1'b0, a} + {1'b0, b});
        @(negedge clk);
        st16 = 1'b0;
        check(busy16 == 1'b1, in_done ? "R8 start in done cycle n16" : "R2 busy after start n16", busy16, 1);
        check(co16 == 1'b0, "R9 carry cleared n16", co16, 0);
    endtask

    task automatic go4(input logic [3:0] a, input logic [3:0] b);
        bit in_done;
        @(negedge clk);
        while (busy4) @(negedge clk);
        in_done = done4;
        st4 = 1'b1; a4 = a; b4 = b;
        q4.push_back({1'b0, a} + {1'b0, b});
        @(negedge clk);
        st4 = 1'b0;
        check(busy4 == 1'b1, in_done ? "R8 start in done cycle n4" : "R2 busy after start n4", busy4, 1);
        check(co4 == 1'b0, "R9 carry cleared n4", co4, 0);
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (busy16 || busy4 || q16.size() != 0 || q4.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy16 == 0 && done16 == 0 && sum16 == 0 && co16 == 0, "R1 reset n16",
              {busy16, done16, co16, sum16}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy4 == 0 && done4 == 0 && sum4 == 0 && co4 == 0, "R1 after reset n4",
              {busy4, done4, co4, sum4}, 0);

        // directed: 0101 + 0011 = 1000, carry 0
        go4(4'b0101, 4'b0011);
        // R9: stale carry 1 then 0 + 0
        go4(4'hF, 4'h1);
        go4(4'h0, 4'h0);
        wait_idle();

        // R7: result held while idle
        go16(16'hFFFF, 16'h0001);
        while (!done16) @(negedge clk);
        repeat (5) begin
            @(negedge clk);
            check(sum16 == 16'h0000 && co16 == 1'b1, "R7 result held", {co16, sum16}, 17'h10000);
        end

        // R6: start during busy ignored
        go16(16'h1234, 16'h4321);
        repeat (3) @(negedge clk);
        st16 = 1'b1; a16 = 16'hFFFF; b16 = 16'hFFFF;
        @(negedge clk);
        st16 = 1'b0;
        check(busy16 == 1'b1, "R6 still busy after ignored start", busy16, 1);
        wait_idle();

        // exhaustive 4-bit, back-to-back
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                go4(4'(i), 4'(j));
        // random 16-bit, back-to-back
        for (int k = 0; k < 200; k++)
            go16(16'($urandom), 16'($urandom));
        go16(16'hFFFF, 16'hFFFF);
        go16(16'h8000, 16'h8000);
        wait_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule